// File: doc/BRIEF.md
# 66-bit Line Block Cipher Stage

This stage encrypts or decrypts 64b/66b line blocks one block per valid cycle. On the transmit side it sits after the block encoder and before the scrambler. On the receive side it sits after the descrambler and before the block decoder. Both sides use the same operation, because XOR with the same keystream undoes itself.

The 64-bit payload is XORed with a 64-bit data keystream word. The 2-bit sync header is first reduced to one bit: `01` becomes 0 and `10` becomes 1. That bit is XORed with a 1-bit sync keystream bit and expanded back into a header. The result is that an encrypted block still carries a legal header with its guaranteed 0/1 transition, and the block type stays hidden.

When the enable input is low, blocks pass through untouched. A block whose header is `00` or `11` is never encrypted: it is passed through with an error flag, and it does not consume keystream. A strobe tells the external keystream generators to step exactly once for every block that was actually ciphered. Output is registered, with one cycle of latency.

Top module: `line_block_cipher`

## Requirements
- R1: For a valid block with a legal header while `cipher_en` is 1, `out_payload` one cycle later equals `in_payload` XOR `ks_data`, bit by bit.
- R2: For such a block, the header is reduced to one bit (`01` gives 0, `10` gives 1). That bit is XORed with `ks_sync`, and the result is expanded back (0 gives `01`, 1 gives `10`). So `ks_sync`=1 swaps `01` and `10`, and `ks_sync`=0 keeps the header.
- R3: While `cipher_en` is 0, a valid block appears one cycle later with header and payload unchanged, whatever the keystream inputs are.
- R4: A valid block with header `00` or `11` appears one cycle later unchanged, with `out_hdr_err` 1, even while `cipher_en` is 1. `out_hdr_err` is 0 for legal headers and whenever `out_valid` is 0.
- R5: `ks_advance` is 1 in the same cycle as an input block exactly when `in_valid`, `cipher_en` and a legal header all hold. It is 0 otherwise, including for invalid headers and idle cycles.
- R6: `out_valid` equals `in_valid` delayed by one clock. Back-to-back blocks produce back-to-back outputs.
- R7: While `rst_n` is 0 and after its release, `out_valid` and `out_hdr_err` are 0 until a block is presented.
- R8: Passing a ciphered block through a second instance of the operation with the same keystream returns the original header and payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block present this cycle |
| in_hdr | input | 2 | Input sync header |
| in_payload | input | 64 | Input block payload |
| ks_data | input | 64 | Data keystream word for this block |
| ks_sync | input | 1 | Sync keystream bit for this block |
| cipher_en | input | 1 | 1 = cipher blocks, 0 = pass through |
| ks_advance | output | 1 | Keystream step request for this block |
| out_valid | output | 1 | Output block present |
| out_hdr | output | 2 | Output sync header |
| out_payload | output | 64 | Output payload |
| out_hdr_err | output | 1 | Output block carried an illegal header |

## Verification
Two functions can land in the same cycle: the header legality check, which sets the error flag and forces pass-through, and the cipher decision, which drives `ks_advance` and the XOR. The bench provokes both at once by presenting `00` and `11` headers with the enable high and a non-zero keystream. It then checks that the error flag rises, that the payload and header are unchanged, and that no keystream step is requested in that same cycle. A separate check toggles the enable between consecutive legal blocks and confirms that each block's treatment follows the enable value sampled with that block.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

   typedef logic [1:0] hdr_t;

   localparam hdr_t HDR_LO = 2'b01;   // carries mapped value 0
   localparam hdr_t HDR_HI = 2'b10;   // carries mapped value 1

   function automatic logic hdr_legal(input hdr_t h);
      return (h == HDR_LO) || (h == HDR_HI);
   endfunction

   function automatic logic hdr_to_bit(input hdr_t h);
      return (h == HDR_HI);
   endfunction

   function automatic hdr_t bit_to_hdr(input logic b);
      return b ? HDR_HI : HDR_LO;
   endfunction

endpackage

// File: rtl/lbc_hdr_cipher.sv
module lbc_hdr_cipher
   import lbc_pkg::*;
(
   input  hdr_t hdr_in,
   input  logic ks_bit,
   input  logic enable,
   output hdr_t hdr_out,
   output logic legal
);
   logic mapped;
   logic mixed;

   always_comb begin
      legal  = hdr_legal(hdr_in);
      mapped = hdr_to_bit(hdr_in);
      mixed  = mapped ^ ks_bit;
      if (enable && legal) hdr_out = bit_to_hdr(mixed);
      else                 hdr_out = hdr_in;
   end
endmodule

// File: rtl/lbc_payload_xor.sv
module lbc_payload_xor #(
   parameter int WIDTH  = 64,
   parameter int LANE_W = 16
) (
   input  logic [WIDTH-1:0] data_in,
   input  logic [WIDTH-1:0] ks_in,
   input  logic             apply,
   output logic [WIDTH-1:0] data_out
);
   localparam int LANES = WIDTH / LANE_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mask;
      assign mask = apply ? ks_in[g*LANE_W +: LANE_W] : '0;
      assign data_out[g*LANE_W +: LANE_W] = data_in[g*LANE_W +: LANE_W] ^ mask;
   end
endmodule

// File: rtl/lbc_stage_reg.sv
module lbc_stage_reg
   import lbc_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_valid,
   input  hdr_t             d_hdr,
   input  logic [WIDTH-1:0] d_payload,
   input  logic             d_err,
   output logic             q_valid,
   output hdr_t             q_hdr,
   output logic [WIDTH-1:0] q_payload,
   output logic             q_err
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid   <= 1'b0;
         q_hdr     <= '0;
         q_payload <= '0;
         q_err     <= 1'b0;
      end else begin
         q_valid <= d_valid;
         q_err   <= d_valid & d_err;
         if (d_valid) begin
            q_hdr     <= d_hdr;
            q_payload <= d_payload;
         end
      end
   end
endmodule

// File: rtl/line_block_cipher.sv
module line_block_cipher
   import lbc_pkg::*;
#(
   parameter int PAYLOAD_W = 64,
   parameter int LANE_W    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           in_hdr,
   input  logic [PAYLOAD_W-1:0] in_payload,
   input  logic [PAYLOAD_W-1:0] ks_data,
   input  logic                 ks_sync,
   input  logic                 cipher_en,
   output logic                 ks_advance,
   output logic                 out_valid,
   output logic [1:0]           out_hdr,
   output logic [PAYLOAD_W-1:0] out_payload,
   output logic                 out_hdr_err
);
   if (PAYLOAD_W < 1 || LANE_W < 1) begin : g_bad_width
      $error("line_block_cipher: widths must be positive");
   end
   if (PAYLOAD_W % LANE_W != 0) begin : g_bad_lane
      $error("line_block_cipher: PAYLOAD_W must be a multiple of LANE_W");
   end

   hdr_t                 hdr_c;
   logic                 hdr_ok;
   logic                 do_cipher;
   logic [PAYLOAD_W-1:0] pl_c;

   assign do_cipher  = in_valid & cipher_en & hdr_ok;
   assign ks_advance = do_cipher;

   lbc_hdr_cipher u_hdr (
      .hdr_in  (in_hdr),
      .ks_bit  (ks_sync),
      .enable  (cipher_en),
      .hdr_out (hdr_c),
      .legal   (hdr_ok)
   );

   lbc_payload_xor #(.WIDTH(PAYLOAD_W), .LANE_W(LANE_W)) u_pl (
      .data_in  (in_payload),
      .ks_in    (ks_data),
      .apply    (cipher_en & hdr_ok),
      .data_out (pl_c)
   );

   lbc_stage_reg #(.WIDTH(PAYLOAD_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .d_valid   (in_valid),
      .d_hdr     (hdr_c),
      .d_payload (pl_c),
      .d_err     (~hdr_ok),
      .q_valid   (out_valid),
      .q_hdr     (out_hdr),
      .q_payload (out_payload),
      .q_err     (out_hdr_err)
   );
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
   parameter int PAYLOAD_W = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [1:0]           in_hdr,
   input logic [PAYLOAD_W-1:0] in_payload,
   input logic [PAYLOAD_W-1:0] ks_data,
   input logic                 ks_sync,
   input logic                 cipher_en,
   input logic                 ks_advance,
   input logic                 out_valid,
   input logic [1:0]           out_hdr,
   input logic [PAYLOAD_W-1:0] out_payload,
   input logic                 out_hdr_err
);
   logic in_legal;
   assign in_legal = (in_hdr == 2'b01) || (in_hdr == 2'b10);

   // R1
   assert_payload_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cipher_en && in_legal) |=> out_payload == ($past(in_payload) ^ $past(ks_data)));

   // R2
   assert_hdr_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cipher_en && in_legal && ks_sync) |=> out_hdr == ~$past(in_hdr));

   // R2
   assert_hdr_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hdr_err) |-> (out_hdr == 2'b01 || out_hdr == 2'b10));

   // R3
   assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cipher_en) |=> (out_payload == $past(in_payload) && out_hdr == $past(in_hdr)));

   // R4
   assert_bad_hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_legal) |=> (out_hdr_err && out_hdr == $past(in_hdr) && out_payload == $past(in_payload)));

   // R4
   assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_hdr_err);

   // R5
   assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ks_advance |-> (in_valid && cipher_en && in_legal));

   // R6
   assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R6
   assert_no_phantom_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
endmodule

bind line_block_cipher lbc_checker #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_hdr      (in_hdr),
   .in_payload  (in_payload),
   .ks_data     (ks_data),
   .ks_sync     (ks_sync),
   .cipher_en   (cipher_en),
   .ks_advance  (ks_advance),
   .out_valid   (out_valid),
   .out_hdr     (out_hdr),
   .out_payload (out_payload),
   .out_hdr_err (out_hdr_err)
);

// File: tb/sim_line_block_cipher.sv
`timescale 1ns/1ps
module sim_line_block_cipher;

   localparam int W = 64;

   typedef struct packed {
      logic         en;
      logic [1:0]   hdr;
      logic [W-1:0] pl;
      logic [W-1:0] ks;
      logic         kss;
      logic [1:0]   exp_hdr;
      logic         exp_xor;
      logic         exp_err;
      logic         exp_adv;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'b01, 64'h0123_4567_89AB_CDEF, 64'hA5A5_5A5A_F00F_0FF0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1},
      '{1'b1, 2'b01, 64'hDEAD_BEEF_0000_FFFF, 64'h1111_2222_3333_4444, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1},
      '{1'b1, 2'b10, 64'h1E00_0000_0000_0000, 64'h8000_0000_0000_0001, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1},
      '{1'b1, 2'b10, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1},
      '{1'b0, 2'b10, 64'hCAFE_F00D_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0},
      '{1'b0, 2'b01, 64'h5555_AAAA_5555_AAAA, 64'h9999_6666_9999_6666, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0},
      '{1'b1, 2'b00, 64'h7777_8888_9999_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0},
      '{1'b1, 2'b11, 64'h0000_0000_0000_0001, 64'h1234_1234_1234_1234, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0},
      '{1'b0, 2'b11, 64'hABCD_EF01_2345_6789, 64'h0000_FFFF_0000_FFFF, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0},
      '{1'b1, 2'b01, 64'h3C3C_3C3C_3C3C_3C3C, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1},
      '{1'b1, 2'b10, 64'h8421_8421_8421_8421, 64'h0000_0000_0000_0000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1},
      '{1'b1, 2'b01, 64'h0000_0000_0000_0000, 64'hFEDC_BA98_7654_3210, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_hdr = 2'b01;
   logic [W-1:0] in_payload = '0;
   logic [W-1:0] ks_data = '0;
   logic         ks_sync = 1'b0;
   logic         cipher_en = 1'b0;
   logic         ks_advance;
   logic         out_valid;
   logic [1:0]   out_hdr;
   logic [W-1:0] out_payload;
   logic         out_hdr_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   line_block_cipher #(.PAYLOAD_W(W), .LANE_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
      .in_payload(in_payload), .ks_data(ks_data), .ks_sync(ks_sync),
      .cipher_en(cipher_en), .ks_advance(ks_advance), .out_valid(out_valid),
      .out_hdr(out_hdr), .out_payload(out_payload), .out_hdr_err(out_hdr_err)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge, check strobe before the edge, check outputs after it
   task automatic apply(input logic en, input logic [1:0] h, input logic [W-1:0] p,
                        input logic [W-1:0] k, input logic ks1,
                        input logic [1:0] eh, input logic [W-1:0] ep,
                        input logic ee, input logic ea, input string tag);
      @(negedge clk);
      in_valid = 1'b1; cipher_en = en; in_hdr = h; in_payload = p;
      ks_data = k; ks_sync = ks1;
      #1;
      chk({tag, " R5 ks_advance"}, W'(ks_advance), W'(ea));
      @(posedge clk); #1;
      chk({tag, " R6 out_valid"}, W'(out_valid), W'(1'b1));
      chk({tag, " R2 out_hdr"}, W'(out_hdr), W'(eh));
      chk({tag, " R1/R3 out_payload"}, out_payload, ep);
      chk({tag, " R4 out_hdr_err"}, W'(out_hdr_err), W'(ee));
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [1:0]   c_hdr;
      logic [W-1:0] c_pl;
      // R7 reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R7 out_valid in reset", W'(out_valid), '0);
      chk("R7 out_hdr_err in reset", W'(out_hdr_err), '0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R7 out_valid after release", W'(out_valid), '0);
      chk("R5 ks_advance idle", W'(ks_advance), '0);

      // table walk: R1 R2 R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].en, VECS[i].hdr, VECS[i].pl, VECS[i].ks, VECS[i].kss,
               VECS[i].exp_hdr,
               VECS[i].exp_xor ? (VECS[i].pl ^ VECS[i].ks) : VECS[i].pl,
               VECS[i].exp_err, VECS[i].exp_adv, $sformatf("vec%0d", i));
      end

      // R6: gap yields no output, no error, no strobe
      @(negedge clk); in_valid = 1'b0; cipher_en = 1'b1; in_hdr = 2'b00;
      #1; chk("R5 no advance when idle", W'(ks_advance), '0);
      @(posedge clk); #1;
      chk("R6 out_valid drops", W'(out_valid), '0);
      chk("R4 err low when not valid", W'(out_hdr_err), '0);

      // R8 involution: cipher then decipher with same keystream
      apply(1'b1, 2'b10, 64'h1E1E_0000_1E1E_0000, 64'h5A5A_C3C3_9696_0F0F, 1'b1,
            2'b01, 64'h1E1E_0000_1E1E_0000 ^ 64'h5A5A_C3C3_9696_0F0F, 1'b0, 1'b1, "enc");
      c_hdr = out_hdr; c_pl = out_payload;
      apply(1'b1, c_hdr, c_pl, 64'h5A5A_C3C3_9696_0F0F, 1'b1,
            2'b10, 64'h1E1E_0000_1E1E_0000, 1'b0, 1'b1, "R8 dec");

      // enable toggled between consecutive blocks, back-to-back (R3, R6)
      apply(1'b0, 2'b01, 64'h1111_1111_1111_1111, 64'hFFFF_0000_0000_0000, 1'b1,
            2'b01, 64'h1111_1111_1111_1111, 1'b0, 1'b0, "R3 toggle off");
      apply(1'b1, 2'b01, 64'h1111_1111_1111_1111, 64'hFFFF_0000_0000_0000, 1'b1,
            2'b10, 64'hEEEE_1111_1111_1111, 1'b0, 1'b1, "R1 toggle on");

      // reset mid-stream clears outputs (R7)
      @(negedge clk); in_valid = 1'b1; in_hdr = 2'b11; rst_n = 1'b0;
      @(posedge clk); #1;
      chk("R7 out_valid under reset", W'(out_valid), '0);
      chk("R7 out_hdr_err under reset", W'(out_hdr_err), '0);
      @(negedge clk); in_valid = 1'b0; rst_n = 1'b1;
      @(posedge clk); #1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule